// File: doc/BRIEF.md
# Segment Address Translator

The block turns a logical offset into a physical address through a small bank of segment registers. Each segment holds a base, a lower limit and an upper limit. A request names one segment and carries an offset. The block checks the offset against that segment's limits and adds the base. One clock later it returns either the translated address or a range fault.

Software, or a controlling agent, loads the segment registers through a simple write port, one field at a time. A segment can be moved in physical memory by rewriting only its base. Logical offsets used by the running code stay the same. A faulted access still completes with a valid pulse, so the requester always gets exactly one response for each request.

Top module: `seg_xlate`

## Requirements
- R1: While reset is high and in the cycle after it is released, rsp_valid, rsp_fault and rsp_paddr are all zero. Every segment field resets to zero, so any request made before a segment is loaded faults.
- R2: A write with wr_en high stores wr_data into the segment named by wr_sel. wr_field selects the field: 0 is the base, 1 is the lower limit and 2 is the upper limit. The value 3 changes nothing.
- R3: For an in-range request, rsp_paddr equals the segment base plus req_addr, modulo 2^32. A result that wraps past the top of the address space is not a fault.
- R4: An offset is in range exactly when lower <= req_addr < upper, compared unsigned. The lower limit is inclusive and the upper limit is exclusive. A segment whose lower limit equals its upper limit accepts no offset.
- R5: For an out-of-range request, rsp_fault is 1, rsp_paddr is 0 and rsp_valid still pulses.
- R6: rsp_valid is high in the cycle after each cycle with req_valid high, and low otherwise. In a cycle without a response, rsp_fault and rsp_paddr are 0. Back-to-back requests each get their own response.
- R7: req_sel picks which of the segments is used. Each segment translates with its own fields, independent of the others.
- R8: A write and a request to the same segment in the same cycle translate with the field values from before the write. The new value applies from the next cycle on.
- R9: Rewriting only the base of a segment moves where a fixed logical offset lands. The same req_addr then maps to the new base plus the offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Segment field write strobe |
| wr_sel | input | 2 | Segment number written |
| wr_field | input | 2 | Field written: 0 base, 1 lower, 2 upper, 3 none |
| wr_data | input | 32 | Value written |
| req_valid | input | 1 | Translation request strobe |
| req_sel | input | 2 | Segment used by the request |
| req_addr | input | 32 | Logical offset |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_paddr | output | 32 | Physical address, zero on fault |
| rsp_fault | output | 1 | Range fault for this response |

## Verification
The assertions assume that reset is held for at least one rising edge before any request. They also assume that req_valid and wr_en are driven to known 0 or 1 values every cycle. No other property of the inputs is relied on: select values, offsets and field codes may take any value, including writes that collide with requests.

The bench raises reset from time zero and drives every strobe low whenever it is not in use. Inputs change only on falling edges, so each rising edge sees settled values.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    localparam int SEG_ADDR_W = 32;
    localparam int SEG_FLD_W  = 2;

    typedef logic [SEG_ADDR_W-1:0] seg_addr_t;

    typedef enum logic [SEG_FLD_W-1:0] {
        FLD_BASE = 2'd0,
        FLD_LOW  = 2'd1,
        FLD_HIGH = 2'd2,
        FLD_NONE = 2'd3
    } seg_field_e;

    typedef struct packed {
        seg_addr_t base;
        seg_addr_t low;
        seg_addr_t high;
    } seg_entry_t;

    typedef struct packed {
        logic      valid;
        logic      fault;
        seg_addr_t paddr;
    } seg_rsp_t;

    // Lower limit inclusive, upper limit exclusive, unsigned compare
    function automatic logic seg_in_window(seg_entry_t e, seg_addr_t off);
        return (off >= e.low) && (off < e.high);
    endfunction

endpackage

// File: rtl/seg_bank.sv
module seg_bank
    import seg_xlate_pkg::*;
#(
    parameter int NUM_SEG = 4,
    localparam int SEL_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [SEL_W-1:0]     wr_sel,
    input  logic [SEG_FLD_W-1:0] wr_field,
    input  seg_addr_t            wr_data,
    input  logic [SEL_W-1:0]     rd_sel,
    output seg_entry_t           rd_entry
);

    seg_entry_t bank [NUM_SEG];

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        seg_entry_t ent_q;
        logic       hit;

        assign hit = wr_en && (wr_sel == SEL_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q <= '0;
            end else if (hit) begin
                case (seg_field_e'(wr_field))
                    FLD_BASE: ent_q.base <= wr_data;
                    FLD_LOW:  ent_q.low  <= wr_data;
                    FLD_HIGH: ent_q.high <= wr_data;
                    default:  ent_q      <= ent_q;
                endcase
            end
        end

        assign bank[g] = ent_q;
    end

    // Read returns the stored value, so a same-cycle write is not yet visible
    assign rd_entry = bank[rd_sel];

endmodule

// File: rtl/seg_limit_add.sv
module seg_limit_add
    import seg_xlate_pkg::*;
(
    input  seg_entry_t entry,
    input  seg_addr_t  offset,
    output logic       in_range,
    output seg_addr_t  sum
);

    assign in_range = seg_in_window(entry, offset);
    assign sum      = entry.base + offset;

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int NUM_SEG = 4,
    localparam int SEL_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [SEL_W-1:0]      wr_sel,
    input  logic [SEG_FLD_W-1:0]  wr_field,
    input  logic [SEG_ADDR_W-1:0] wr_data,
    input  logic                  req_valid,
    input  logic [SEL_W-1:0]      req_sel,
    input  logic [SEG_ADDR_W-1:0] req_addr,
    output logic                  rsp_valid,
    output logic [SEG_ADDR_W-1:0] rsp_paddr,
    output logic                  rsp_fault
);

    seg_entry_t sel_entry;
    logic       ok;
    seg_addr_t  sum;
    seg_rsp_t   rsp_d, rsp_q;

    seg_bank #(.NUM_SEG(NUM_SEG)) bank_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_field (wr_field),
        .wr_data  (wr_data),
        .rd_sel   (req_sel),
        .rd_entry (sel_entry)
    );

    seg_limit_add calc_i (
        .entry    (sel_entry),
        .offset   (req_addr),
        .in_range (ok),
        .sum      (sum)
    );

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            rsp_d.fault = !ok;
            rsp_d.paddr = ok ? sum : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rsp_q <= '0;
        else     rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_fault = rsp_q.fault;
    assign rsp_paddr = rsp_q.paddr;

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              rsp_valid,
    input logic              rsp_fault,
    input logic [ADDR_W-1:0] rsp_paddr
);

    assert_rsp_follows_req_R6: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_no_rsp_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    assert_fault_zero_addr_R5: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> (rsp_paddr == '0));

    assert_fault_needs_valid_R5: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> rsp_valid);

    assert_idle_addr_zero_R6: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (rsp_paddr == '0));

endmodule

bind seg_xlate seg_xlate_chk #(.ADDR_W(seg_xlate_pkg::SEG_ADDR_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .rsp_paddr (rsp_paddr)
);

// File: tb/seg_xlate_tb_top.sv
module seg_xlate_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [1:0]  wr_field = '0;
    logic [31:0] wr_data = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_sel = '0;
    logic [31:0] req_addr = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_fault;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    seg_xlate dut_i (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_field(wr_field), .wr_data(wr_data),
        .req_valid(req_valid), .req_sel(req_sel), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
    );

    localparam int NV = 10;
    localparam logic [1:0]  V_SEL   [NV] = '{0, 0, 0, 0, 1, 1, 2, 2, 3, 1};
    localparam logic [31:0] V_ADDR  [NV] = '{32'h100, 32'h1FF, 32'h200, 32'hFF,
                                             32'h0, 32'hFFF, 32'h100, 32'h20,
                                             32'h5000, 32'hFFFF_FFFF};
    localparam logic [31:0] V_PADDR [NV] = '{32'h1000_0100, 32'h1000_01FF, 32'h0, 32'h0,
                                             32'h8000_0000, 32'h8000_0FFF, 32'h0, 32'hFFFF_FF20,
                                             32'h0, 32'h0};
    localparam logic        V_FAULT [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0,
                                             1'b1, 1'b1};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_rsp(input string req, input logic [31:0] ep, input logic ef);
        chk(req, {31'd0, rsp_valid}, 32'd1);
        chk(req, {31'd0, rsp_fault}, {31'd0, ef});
        chk(req, rsp_paddr, ep);
    endtask

    task automatic wr(input logic [1:0] s, input logic [1:0] f, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_field = f; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rq(input logic [1:0] s, input logic [31:0] a,
                      input logic [31:0] ep, input logic ef, input string req);
        @(negedge clk);
        req_valid = 1'b1; req_sel = s; req_addr = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk_rsp(req, ep, ef);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 valid in reset", {31'd0, rsp_valid}, 32'd0);
        chk("R1 fault in reset", {31'd0, rsp_fault}, 32'd0);
        chk("R1 paddr in reset", rsp_paddr, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 valid after reset", {31'd0, rsp_valid}, 32'd0);
        rq(2'd0, 32'h0, 32'h0, 1'b1, "R1 unloaded segment faults");

        // R2: load segments
        wr(0, 0, 32'h1000_0000); wr(0, 1, 32'h100);  wr(0, 2, 32'h200);
        wr(1, 0, 32'h8000_0000); wr(1, 1, 32'h0);    wr(1, 2, 32'h1000);
        wr(2, 0, 32'hFFFF_FF00); wr(2, 1, 32'h10);   wr(2, 2, 32'h400);
        wr(3, 0, 32'h0);         wr(3, 1, 32'h5000); wr(3, 2, 32'h5000);

        // R3 R4 R5 R7: vector table
        for (int i = 0; i < NV; i++) begin
            rq(V_SEL[i], V_ADDR[i], V_PADDR[i], V_FAULT[i],
               $sformatf("R3/R4/R5/R7 vector %0d", i));
        end

        // R2: field code 3 has no effect on segment 0
        wr(0, 3, 32'hDEAD_BEEF);
        rq(2'd0, 32'h150, 32'h1000_0150, 1'b0, "R2 field 3 ignored");

        // R6: idle cycle gives no response
        @(negedge clk);
        chk("R6 idle valid", {31'd0, rsp_valid}, 32'd0);
        chk("R6 idle fault", {31'd0, rsp_fault}, 32'd0);
        chk("R6 idle paddr", rsp_paddr, 32'd0);

        // R6: back-to-back requests
        @(negedge clk);
        req_valid = 1'b1; req_sel = 2'd1; req_addr = 32'h40;
        @(negedge clk);
        chk_rsp("R6 back-to-back first", 32'h8000_0040, 1'b0);
        req_sel = 2'd0; req_addr = 32'h300;
        @(negedge clk);
        req_valid = 1'b0;
        chk_rsp("R6 back-to-back second", 32'h0, 1'b1);

        // R8: write and request to same segment in same cycle
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd1; wr_field = 2'd0; wr_data = 32'h9000_0000;
        req_valid = 1'b1; req_sel = 2'd1; req_addr = 32'h10;
        @(negedge clk);
        wr_en = 1'b0; req_valid = 1'b0;
        chk_rsp("R8 same-cycle write uses old base", 32'h8000_0010, 1'b0);

        // R9: relocated base applies to the same offset
        rq(2'd1, 32'h10, 32'h9000_0010, 1'b0, "R9 relocation");

        // R8: new upper limit visible next cycle
        wr(0, 2, 32'h400);
        rq(2'd0, 32'h300, 32'h1000_0300, 1'b0, "R8 new upper limit applies");

        finish_run();
    end

endmodule